// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block produces the two timing strobes of an external memory bus: an active-high address latch pulse and an active-low program-fetch read strobe. Both are derived from a free-running 12-clock machine cycle. In steady state the latch pulse fires twice per machine cycle, once every six clocks. When code is fetched from external memory, the fetch strobe also fires twice per machine cycle.

Three conditions change this pattern. A machine cycle flagged as an external data transfer drops the second latch pulse and both fetch strobes. A software-written disable bit holds the latch output at its idle high level, except in cycles that carry an external move instruction. The disable bit is ignored while the core executes from external program memory.

The cycle qualifiers (data transfer, move instruction, execution mode) are captured once per machine cycle, on the edge that ends phase 11. The strobes are then decoded from fixed windows of the phase counter. The address/data multiplexing that uses these strobes lies outside this block.

Top module: `ext_bus_strobe_seq`

## Requirements
- R1: The phase counter counts 0 to 11 and wraps to 0. Reset clears the phase, the captured qualifiers and the disable bit, so after reset the latch output is high in phases 0, 1, 6 and 7 and the fetch strobe is high (inactive).
- R2: With no data transfer and no gating, `ale_o` is 1 in phases 0, 1, 6 and 7 and 0 in every other phase: two pulses per 12 clocks.
- R3: In a machine cycle captured with `xdata_cycle_i`=1, the latch pulse in phases 6 and 7 is omitted (`ale_o`=0). The pulse in phases 0 and 1 remains.
- R4: In a cycle captured with `ext_exec_i`=1 and no data transfer, `psen_n_o` is 0 in phases 3, 4, 9 and 10 and 1 elsewhere.
- R5: In a cycle captured with `xdata_cycle_i`=1, `psen_n_o` stays 1 for the whole cycle.
- R6: In a cycle captured with `ext_exec_i`=0, `psen_n_o` stays 1 for the whole cycle.
- R7: When the disable bit is 1 and the cycle was captured with `ext_exec_i`=0 and `move_instr_i`=0, `ale_o` is held at 1 in every phase.
- R8: When the disable bit is 1 but the cycle was captured with `move_instr_i`=1, `ale_o` follows R2 and R3.
- R9: When the cycle was captured with `ext_exec_i`=1, the disable bit has no effect and `ale_o` follows R2 and R3.
- R10: The qualifiers are sampled only on the clock edge that leaves phase 11. Changes to them at any other time have no effect on the strobes until that edge.
- R11: When `ale_dis_we_i`=1 at a clock edge, the disable bit loads `ale_dis_val_i` on that edge and governs `ale_o` from the next clock onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xdata_cycle_i | input | 1 | Next machine cycle is an external data transfer |
| move_instr_i | input | 1 | Next machine cycle belongs to an external move instruction |
| ext_exec_i | input | 1 | Core executes from external program memory |
| ale_dis_we_i | input | 1 | Write strobe for the latch-disable bit |
| ale_dis_val_i | input | 1 | Value written to the latch-disable bit |
| ale_o | output | 1 | Address latch pulse, active high, idle high when gated |
| psen_n_o | output | 1 | Program fetch read strobe, active low |

## Verification
The bench targets the data-transfer cycle. A design that drops the wrong latch pulse would leave phase 6 high or phase 0 low, and one that keeps the fetch strobes would pull `psen_n_o` low at phases 3 or 9. It toggles the qualifiers in the middle of a cycle. A design that samples them continuously rather than at the wrap would change the strobes too early. It also walks through the disable bit with each override: a design that ignores the move-instruction or external-execution override would hold `ale_o` high where it must pulse, and one that gates to the wrong level would drive 0 where the idle level is 1.

// File: rtl/ext_bus_strobe_pkg.sv
package ext_bus_strobe_pkg;
  typedef struct packed {
    logic xdata;
    logic move;
    logic ext;
  } cyc_qual_t;
endpackage

// File: rtl/strobe_phase_ctr.sv
module strobe_phase_ctr #(
  parameter int CYCLE_LEN = 12,
  localparam int PW = $clog2(CYCLE_LEN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [PW-1:0] phase_o,
  output logic          last_o
);
  localparam logic [PW-1:0] LAST = PW'(CYCLE_LEN - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      phase_o <= '0;
    else if (last_o)  phase_o <= '0;
    else              phase_o <= phase_o + 1'b1;
  end

  assign last_o = (phase_o == LAST);

  AST_PHASE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, phase_o} < (PW+1)'(CYCLE_LEN)); // R1
  AST_PHASE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (phase_o == '0)); // R1
endmodule

// File: rtl/strobe_cycle_latch.sv
module strobe_cycle_latch
  import ext_bus_strobe_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      last_i,
  input  cyc_qual_t qual_d_i,
  output cyc_qual_t qual_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     qual_q_o <= '0;
    else if (last_i) qual_q_o <= qual_d_i;
  end

  AST_QUAL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_i |=> $stable(qual_q_o)); // R10
endmodule

// File: rtl/strobe_decode.sv
module strobe_decode
  import ext_bus_strobe_pkg::*;
#(
  parameter int CYCLE_LEN = 12,
  parameter int ALE_W     = 2,
  parameter int PS_OFF    = 3,
  parameter int PS_W      = 2,
  localparam int PW   = $clog2(CYCLE_LEN),
  localparam int HALF = CYCLE_LEN / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] phase_i,
  input  cyc_qual_t     qual_i,
  input  logic          dis_i,
  output logic          ale_o,
  output logic          psen_n_o
);
  logic [1:0] ale_slot, ps_slot;

  // one latch window and one fetch window per half machine cycle
  for (genvar g = 0; g < 2; g++) begin : g_slot
    localparam int ABASE = g * HALF;
    localparam int PBASE = g * HALF + PS_OFF;
    logic [PW-1:0] arel, prel;
    assign arel        = phase_i - PW'(ABASE);
    assign prel        = phase_i - PW'(PBASE);
    assign ale_slot[g] = (arel < PW'(ALE_W));
    assign ps_slot[g]  = (prel < PW'(PS_W));
  end

  logic gated;
  assign gated = dis_i && !qual_i.ext && !qual_i.move;

  always_comb begin
    if (gated) ale_o = 1'b1;  // idle level while gated
    else       ale_o = ale_slot[0] || (ale_slot[1] && !qual_i.xdata);
    psen_n_o = !(qual_i.ext && !qual_i.xdata && (|ps_slot));
  end

  AST_PSEN_INTERNAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !qual_i.ext |-> psen_n_o); // R6
  AST_PSEN_XDATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qual_i.xdata |-> psen_n_o); // R5
  AST_ALE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dis_i && !qual_i.ext && !qual_i.move) |-> ale_o); // R7
  AST_ALE_XDATA_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qual_i.xdata && !gated && phase_i == PW'(HALF)) |-> !ale_o); // R3
endmodule

// File: rtl/ext_bus_strobe_seq.sv
module ext_bus_strobe_seq
  import ext_bus_strobe_pkg::*;
#(
  parameter int CYCLE_LEN = 12,
  parameter int ALE_W     = 2,
  parameter int PS_OFF    = 3,
  parameter int PS_W      = 2,
  localparam int PW = $clog2(CYCLE_LEN)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic xdata_cycle_i,
  input  logic move_instr_i,
  input  logic ext_exec_i,
  input  logic ale_dis_we_i,
  input  logic ale_dis_val_i,
  output logic ale_o,
  output logic psen_n_o
);
  logic [PW-1:0] phase;
  logic          last;
  cyc_qual_t     qual_d, qual_q;
  logic          dis_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           dis_q <= 1'b0;
    else if (ale_dis_we_i) dis_q <= ale_dis_val_i;
  end

  assign qual_d = '{xdata: xdata_cycle_i, move: move_instr_i, ext: ext_exec_i};

  strobe_phase_ctr #(.CYCLE_LEN(CYCLE_LEN)) u_ctr (
    .clk_i, .rst_ni, .phase_o(phase), .last_o(last)
  );

  strobe_cycle_latch u_latch (
    .clk_i, .rst_ni, .last_i(last), .qual_d_i(qual_d), .qual_q_o(qual_q)
  );

  strobe_decode #(
    .CYCLE_LEN(CYCLE_LEN), .ALE_W(ALE_W), .PS_OFF(PS_OFF), .PS_W(PS_W)
  ) u_dec (
    .clk_i, .rst_ni, .phase_i(phase), .qual_i(qual_q), .dis_i(dis_q),
    .ale_o, .psen_n_o
  );

  AST_DIS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_dis_we_i |=> (dis_q == $past(ale_dis_val_i))); // R11
endmodule

// File: tb/ext_bus_strobe_seq_tb.sv
`timescale 1ns/1ps
module ext_bus_strobe_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic xdata = 1'b0, mv = 1'b0, ext = 1'b0, dwe = 1'b0, dval = 1'b0;
  logic ale, psen_n;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  string tag_ovr = "";

  always #2 clk = ~clk;

  ext_bus_strobe_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .xdata_cycle_i(xdata), .move_instr_i(mv),
    .ext_exec_i(ext), .ale_dis_we_i(dwe), .ale_dis_val_i(dval),
    .ale_o(ale), .psen_n_o(psen_n)
  );

  // independent model state
  int m_phase = 0;
  bit m_x = 0, m_mv = 0, m_ext = 0, m_dis = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase <= 0; m_x <= 0; m_mv <= 0; m_ext <= 0; m_dis <= 0;
    end else begin
      if (dwe) m_dis <= dval;
      if (m_phase == 11) begin m_x <= xdata; m_mv <= mv; m_ext <= ext; end
      m_phase <= (m_phase == 11) ? 0 : m_phase + 1;
    end
  end

  function automatic bit exp_ale(int ph, bit x, bit m, bit e, bit d);
    if (d && !e && !m) return 1'b1;
    return (ph < 2) || (ph >= 6 && ph < 8 && !x);
  endfunction

  function automatic bit exp_psen_n(int ph, bit x, bit e);
    if (!e || x) return 1'b1;
    return !((ph >= 3 && ph < 5) || (ph >= 9 && ph < 11));
  endfunction

  function automatic string ale_tag();
    if (tag_ovr != "") return tag_ovr;
    if (m_dis && !m_ext && !m_mv) return "R7";
    if (m_dis && m_ext) return "R9";
    if (m_dis && m_mv) return "R8";
    if (m_x) return "R3";
    return "R2";
  endfunction

  function automatic string psen_tag();
    if (tag_ovr != "") return tag_ovr;
    if (!m_ext) return "R6";
    if (m_x) return "R5";
    return "R4";
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      bit ea, ep;
      ea = exp_ale(m_phase, m_x, m_mv, m_ext, m_dis);
      ep = exp_psen_n(m_phase, m_x, m_ext);
      checks += 2;
      if (ale !== ea) begin
        errors++;
        $display("FAIL %s ale_o phase %0d actual %b expected %b", ale_tag(), m_phase, ale, ea);
      end
      if (psen_n !== ep) begin
        errors++;
        $display("FAIL %s psen_n_o phase %0d actual %b expected %b", psen_tag(), m_phase, psen_n, ep);
      end
    end
  end

  task automatic wait_phase(int ph);
    do @(negedge clk); while (m_phase != ph);
  endtask

  task automatic write_dis(bit v);
    @(negedge clk); dwe = 1'b1; dval = v;
    @(negedge clk); dwe = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    // R1: reset state and start phase
    tag_ovr = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    tag_ovr = "";

    // R2 R4: plain external fetch cycles
    ext = 1'b1;
    repeat (30) @(negedge clk);

    // R3 R5: one data-transfer cycle
    wait_phase(5); xdata = 1'b1;
    wait_phase(5); xdata = 1'b0;
    repeat (24) @(negedge clk);

    // R10: qualifier pulse that never spans the wrap edge
    wait_phase(2); xdata = 1'b1; ext = 1'b0;
    wait_phase(10); xdata = 1'b0; ext = 1'b1;
    tag_ovr = "R10";
    repeat (14) @(negedge clk);
    tag_ovr = "";

    // R11 then R7: disable with internal execution
    ext = 1'b0; mv = 1'b0;
    repeat (12) @(negedge clk);
    tag_ovr = "R11";
    write_dis(1'b1);
    repeat (3) @(negedge clk);
    tag_ovr = "";
    repeat (24) @(negedge clk);
    // R8: move instruction overrides the gate, with and without data transfer
    mv = 1'b1;
    repeat (24) @(negedge clk);
    xdata = 1'b1;
    repeat (24) @(negedge clk);
    xdata = 1'b0; mv = 1'b0;
    // R9: external execution overrides the gate
    ext = 1'b1;
    repeat (24) @(negedge clk);
    ext = 1'b0;
    repeat (12) @(negedge clk);
    write_dis(1'b0);
    repeat (12) @(negedge clk);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      xdata = ($urandom_range(0, 3) == 0);
      mv    = ($urandom_range(0, 3) == 0);
      ext   = ($urandom_range(0, 1) == 1);
      dwe   = ($urandom_range(0, 49) == 0);
      dval  = $urandom_range(0, 1);
    end
    @(negedge clk); dwe = 1'b0;
    repeat (12) @(negedge clk);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule